// File: doc/BRIEF.md
# Posted write bridge controller

This block sits between an on-chip bus slave port and a simplified external bus master. It takes write bursts from on-chip initiators, stores up to sixteen words in a local FIFO and replays them on the external side as one incrementing burst. When posted handling is selected, the on-chip transaction is complete once the last word has been stored. Any on-chip write that arrives while the replay is still running is refused with a retry response. When non-posted handling is selected, the initiator waits until the external write ends and then gets either an okay or an error response.

On-chip bursts are cut with a disconnect response after sixteen words. They are also cut at the last word of a 64-byte aligned region. If the external side aborts a posted write, the buffered words are dropped. Four sticky status flags record the abort kind, and an interrupt is raised through a per-flag mask.

Top module: `pw_bridge`

## Requirements
- R1: After reset, s_ready_o is 1, m_req_o is 0, sts_o is 4'b0000 and irq_o is 0.
- R2: With hold_mode_i=0 sampled on the first beat, s_ok_o is 1 in the same cycle that the final beat of the burst is accepted. The final beat is the one with s_last_i=1 or the one with s_disc_o=1.
- R3: The external burst carries the accepted words in order. Beat k has m_addr_o equal to start address + 4*k, and m_last_o is 1 only on the final beat.
- R4: From the end of a burst until its external replay has finished, a first beat presented on the slave port gets s_retry_o=1 and s_ready_o=0.
- R5: After the replay finishes, s_ready_o returns to 1 and a new burst is accepted.
- R6: A burst is never longer than 16 beats. If s_last_i is still 0 on the 16th accepted beat, s_disc_o=1 on that beat.
- R7: A beat whose address bits [5:2] equal 4'hF ends the burst. If s_last_i=0 on that beat, s_disc_o=1 on it.
- R8: A posted write aborted by m_tabort_i sets sts_o bits 0 and 2. One aborted by m_mabort_i sets sts_o bits 1 and 3. The flags stay set until a 1 is written to the matching bit of sts_clr_i.
- R9: After an abort, m_req_o falls and the remaining buffered words are never sent. The block then accepts new writes.
- R10: irq_o is the OR of sts_o & ~irq_mask_i.
- R11: With hold_mode_i=1 on the first beat, s_ok_o is 0 when the final beat is accepted. It pulses only after every external beat has completed. On an abort, s_err_o pulses instead and sts_o is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hold_mode_i | input | 1 | 0 = posted, 1 = non-posted; sampled on the first beat |
| s_valid_i | input | 1 | On-chip beat valid |
| s_addr_i | input | 32 | Burst start address, used on the first beat |
| s_data_i | input | 32 | On-chip write data |
| s_last_i | input | 1 | Last beat from the initiator |
| s_ready_o | output | 1 | Beat accepted when high with s_valid_i |
| s_retry_o | output | 1 | Write refused, try again later |
| s_disc_o | output | 1 | This beat is taken and the burst is cut |
| s_ok_o | output | 1 | Transaction completed without error |
| s_err_o | output | 1 | Non-posted transaction aborted externally |
| m_req_o | output | 1 | External beat request |
| m_addr_o | output | 32 | External beat address |
| m_data_o | output | 32 | External beat data |
| m_last_o | output | 1 | Final external beat |
| m_ack_i | input | 1 | External beat done |
| m_tabort_i | input | 1 | Target abort from the external side |
| m_mabort_i | input | 1 | Master abort on the external side |
| sts_clr_i | input | 4 | Write-one-to-clear strobes for sts_o |
| irq_mask_i | input | 4 | Per-flag interrupt mask, 1 = masked |
| sts_o | output | 4 | Sticky flags: 0 wr target abort, 1 wr master abort, 2 rx target abort, 3 rx master abort |
| irq_o | output | 1 | Interrupt |

## Verification
A wrong FIFO pointer or beat counter shows up as wrong data, a wrong address or a misplaced m_last_o within the same replay. The bench compares every external beat against the words it sent. A slave-port state machine stuck in its busy state shows up as a retry or a missing s_ready_o on the next burst. A failed flush leaves m_req_o high within a cycle or two of an abort. Flag errors show on sts_o and irq_o two cycles after the abort.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    IN_IDLE = 2'd0,
    IN_RECV = 2'd1,
    IN_HOLD = 2'd2,
    IN_WAIT = 2'd3
  } in_state_e;

  localparam int unsigned FLG_WR_TAB = 0;
  localparam int unsigned FLG_WR_MAB = 1;
  localparam int unsigned FLG_RX_TAB = 2;
  localparam int unsigned FLG_RX_MAB = 3;
  localparam int unsigned FLG_N      = 4;
endpackage

// File: rtl/pw_fifo.sv
module pw_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;

  assign rdata_o = mem_q[rptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (wr_i && !full_o) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_i && !full_o)
        wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (rd_i && !empty_o)
        rptr_q <= (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({wr_i && !full_o, rd_i && !empty_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_o); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !flush_i) |-> !empty_o); // R3
endmodule

// File: rtl/pw_ingress.sv
module pw_ingress
  import pw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MAX_BEATS = 16,
  parameter int unsigned BOUND_B   = 64
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           hold_mode_i,
  input  logic                           s_valid_i,
  input  logic [ADDR_W-1:0]              s_addr_i,
  input  logic                           s_last_i,
  output logic                           s_ready_o,
  output logic                           s_retry_o,
  output logic                           s_disc_o,
  output logic                           s_ok_o,
  output logic                           s_err_o,
  input  logic                           fin_i,
  input  logic                           fin_abort_i,
  output logic                           push_o,
  output logic                           launch_o,
  output logic [ADDR_W-1:0]              launch_base_o,
  output logic [$clog2(MAX_BEATS+1)-1:0] launch_len_o,
  output logic                           posted_wait_o
);
  localparam int unsigned IDX_W = $clog2(BOUND_B / 4);
  localparam int unsigned LEN_W = $clog2(MAX_BEATS + 1);

  in_state_e         state_q, state_d;
  logic              np_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  cnt_q;

  logic             first, acc, cut, fin_beat, np_now;
  logic [IDX_W-1:0] idx_now;
  logic [LEN_W-1:0] cnt_now;

  assign first   = (state_q == IN_IDLE);
  assign np_now  = first ? hold_mode_i : np_q;
  assign idx_now = first ? s_addr_i[IDX_W+1:2] : idx_q;
  assign cnt_now = first ? '0 : cnt_q;

  assign s_ready_o = (state_q == IN_IDLE) || (state_q == IN_RECV);
  assign acc       = s_valid_i && s_ready_o;
  // boundary: last word of the aligned region; length: last permitted beat
  assign cut       = (idx_now == '1) || (cnt_now == LEN_W'(MAX_BEATS - 1));
  assign fin_beat  = acc && (s_last_i || cut);

  assign s_disc_o  = acc && cut && !s_last_i;
  assign s_retry_o = s_valid_i && ((state_q == IN_HOLD) || (state_q == IN_WAIT));
  assign s_ok_o    = (fin_beat && !np_now) ||
                     ((state_q == IN_WAIT) && fin_i && !fin_abort_i);
  assign s_err_o   = (state_q == IN_WAIT) && fin_i && fin_abort_i;

  assign push_o        = acc;
  assign launch_o      = fin_beat;
  assign launch_base_o = first ? s_addr_i : base_q;
  assign launch_len_o  = cnt_now + 1'b1;
  assign posted_wait_o = (state_q == IN_HOLD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      IN_IDLE, IN_RECV: begin
        if (fin_beat)  state_d = np_now ? IN_WAIT : IN_HOLD;
        else if (acc)  state_d = IN_RECV;
      end
      IN_HOLD, IN_WAIT: if (fin_i) state_d = IN_IDLE;
      default: state_d = IN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= IN_IDLE;
      np_q    <= 1'b0;
      base_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (acc) begin
        idx_q <= idx_now + 1'b1;
        cnt_q <= cnt_now + 1'b1;
        if (first) begin
          base_q <= s_addr_i;
          np_q   <= hold_mode_i;
        end
      end
    end
  end

  AST_RETRY_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_retry_o |-> !s_ready_o); // R4
  AST_DISC_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_disc_o |-> (s_valid_i && s_ready_o && !s_last_i)); // R6
  AST_OK_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_ok_o && s_err_o)); // R11
endmodule

// File: rtl/pw_egress.sv
module pw_egress #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MAX_BEATS = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           launch_i,
  input  logic [ADDR_W-1:0]              launch_base_i,
  input  logic [$clog2(MAX_BEATS+1)-1:0] launch_len_i,
  input  logic                           m_ack_i,
  input  logic                           m_tabort_i,
  input  logic                           m_mabort_i,
  output logic                           m_req_o,
  output logic [ADDR_W-1:0]              m_addr_o,
  output logic                           m_last_o,
  output logic                           pop_o,
  output logic                           flush_o,
  output logic                           fin_o,
  output logic                           fin_tab_o,
  output logic                           fin_mab_o
);
  localparam int unsigned LEN_W = $clog2(MAX_BEATS + 1);

  logic              run_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q, beat_q;
  logic              fin_q, tab_q, mab_q;
  logic              abort;

  assign m_req_o   = run_q;
  assign m_addr_o  = base_q + ADDR_W'({beat_q, 2'b00});
  assign m_last_o  = run_q && (beat_q == len_q - 1'b1);
  assign abort     = run_q && (m_tabort_i || m_mabort_i);
  assign pop_o     = run_q && m_ack_i && !abort;
  assign flush_o   = abort;
  assign fin_o     = fin_q;
  assign fin_tab_o = tab_q;
  assign fin_mab_o = mab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      base_q <= '0;
      len_q  <= '0;
      beat_q <= '0;
      fin_q  <= 1'b0;
      tab_q  <= 1'b0;
      mab_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      tab_q <= 1'b0;
      mab_q <= 1'b0;
      if (!run_q) begin
        if (launch_i) begin
          run_q  <= 1'b1;
          base_q <= launch_base_i;
          len_q  <= launch_len_i;
          beat_q <= '0;
        end
      end else if (abort) begin
        run_q <= 1'b0;
        fin_q <= 1'b1;
        tab_q <= m_tabort_i;
        mab_q <= m_mabort_i;
      end else if (m_ack_i) begin
        beat_q <= beat_q + 1'b1;
        if (m_last_o) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (len_q != '0 && beat_q < len_q)); // R3
  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> !launch_i); // R4
endmodule

// File: rtl/pw_status.sv
module pw_status
  import pw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_tab_i,
  input  logic             set_mab_i,
  input  logic [FLG_N-1:0] clr_i,
  input  logic [FLG_N-1:0] mask_i,
  output logic [FLG_N-1:0] sts_o,
  output logic             irq_o
);
  logic [FLG_N-1:0] flg_q, set_v;

  always_comb begin
    set_v             = '0;
    set_v[FLG_WR_TAB] = set_tab_i;
    set_v[FLG_RX_TAB] = set_tab_i;
    set_v[FLG_WR_MAB] = set_mab_i;
    set_v[FLG_RX_MAB] = set_mab_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~clr_i) | set_v;
  end

  assign sts_o = flg_q;
  assign irq_o = |(flg_q & ~mask_i);

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg_q[FLG_WR_TAB] && !clr_i[FLG_WR_TAB]) |=> flg_q[FLG_WR_TAB]); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o == '0) |-> !irq_o); // R10
endmodule

// File: rtl/pw_bridge.sv
module pw_bridge
  import pw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MAX_BEATS = 16,
  parameter int unsigned BOUND_B   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_mode_i,
  input  logic              s_valid_i,
  input  logic [ADDR_W-1:0] s_addr_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              s_retry_o,
  output logic              s_disc_o,
  output logic              s_ok_o,
  output logic              s_err_o,
  output logic              m_req_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_last_o,
  input  logic              m_ack_i,
  input  logic              m_tabort_i,
  input  logic              m_mabort_i,
  input  logic [FLG_N-1:0]  sts_clr_i,
  input  logic [FLG_N-1:0]  irq_mask_i,
  output logic [FLG_N-1:0]  sts_o,
  output logic              irq_o
);
  localparam int unsigned LEN_W = $clog2(MAX_BEATS + 1);

  logic              push, launch, posted_wait;
  logic [ADDR_W-1:0] launch_base;
  logic [LEN_W-1:0]  launch_len;
  logic              pop, flush, fin, fin_tab, fin_mab;
  logic              fifo_empty, fifo_full;

  pw_ingress #(.ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS), .BOUND_B(BOUND_B)) u_in (
    .clk_i, .rst_ni, .hold_mode_i, .s_valid_i, .s_addr_i, .s_last_i,
    .s_ready_o, .s_retry_o, .s_disc_o, .s_ok_o, .s_err_o,
    .fin_i(fin), .fin_abort_i(fin_tab || fin_mab),
    .push_o(push), .launch_o(launch), .launch_base_o(launch_base),
    .launch_len_o(launch_len), .posted_wait_o(posted_wait)
  );

  pw_fifo #(.DATA_W(DATA_W), .DEPTH(MAX_BEATS)) u_fifo (
    .clk_i, .rst_ni, .wr_i(push), .wdata_i(s_data_i), .rd_i(pop),
    .flush_i(flush), .rdata_o(m_data_o), .empty_o(fifo_empty), .full_o(fifo_full)
  );

  pw_egress #(.ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS)) u_eg (
    .clk_i, .rst_ni, .launch_i(launch), .launch_base_i(launch_base),
    .launch_len_i(launch_len), .m_ack_i, .m_tabort_i, .m_mabort_i,
    .m_req_o, .m_addr_o, .m_last_o, .pop_o(pop), .flush_o(flush),
    .fin_o(fin), .fin_tab_o(fin_tab), .fin_mab_o(fin_mab)
  );

  pw_status u_sts (
    .clk_i, .rst_ni,
    .set_tab_i(fin && fin_tab && posted_wait),
    .set_mab_i(fin && fin_mab && posted_wait),
    .clr_i(sts_clr_i), .mask_i(irq_mask_i), .sts_o, .irq_o
  );

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o |-> !s_ready_o); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && (m_tabort_i || m_mabort_i)) |=> (fifo_empty && !m_req_o)); // R9
  AST_LAST_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && m_last_o && m_ack_i && !m_tabort_i && !m_mabort_i) |=> fifo_empty); // R3
  AST_FULL_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full |-> !s_ready_o); // R6
endmodule

// File: tb/pw_bridge_tb.sv
module pw_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold_mode_i = 1'b0;
  logic        s_valid_i = 1'b0;
  logic [31:0] s_addr_i = '0;
  logic [31:0] s_data_i = '0;
  logic        s_last_i = 1'b0;
  logic        s_ready_o, s_retry_o, s_disc_o, s_ok_o, s_err_o;
  logic        m_req_o, m_last_o;
  logic [31:0] m_addr_o, m_data_o;
  logic        m_ack_i = 1'b0, m_tabort_i = 1'b0, m_mabort_i = 1'b0;
  logic [3:0]  sts_clr_i = '0, irq_mask_i = '0;
  logic [3:0]  sts_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;
  bit ack_en = 1'b0;
  int abort_req = 0;
  logic [31:0] cap_addr [32], cap_data [32], exp_addr [32], exp_data [32];
  bit          cap_last [32];
  int cap_n = 0;
  int acc_n;
  bit got_disc, ok_final, early_ok;

  always #5 clk = ~clk;

  pw_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hold_mode_i, .s_valid_i, .s_addr_i, .s_data_i,
    .s_last_i, .s_ready_o, .s_retry_o, .s_disc_o, .s_ok_o, .s_err_o,
    .m_req_o, .m_addr_o, .m_data_o, .m_last_o, .m_ack_i, .m_tabort_i,
    .m_mabort_i, .sts_clr_i, .irq_mask_i, .sts_o, .irq_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_cut(input logic [31:0] a, input int len);
    int room = 16 - int'(a[5:2]);
    return (len < room) ? len : room;
  endfunction

  // external target model
  initial begin
    forever begin
      @(negedge clk);
      m_ack_i = 1'b0; m_tabort_i = 1'b0; m_mabort_i = 1'b0;
      if (m_req_o) begin
        if (abort_req == 1) begin m_tabort_i = 1'b1; abort_req = 0; end
        else if (abort_req == 2) begin m_mabort_i = 1'b1; abort_req = 0; end
        else if (ack_en && ($urandom % 3 != 0)) begin
          m_ack_i = 1'b1;
          if (cap_n < 32) begin
            cap_addr[cap_n] = m_addr_o;
            cap_data[cap_n] = m_data_o;
            cap_last[cap_n] = m_last_o;
          end
          cap_n++;
        end
      end
    end
  end

  task automatic send_burst(input logic [31:0] a, input int len, input logic np);
    int k = 0;
    bit done = 1'b0;
    got_disc = 0; ok_final = 0; early_ok = 0; cap_n = 0;
    while (!done) begin
      @(negedge clk);
      hold_mode_i = np;
      s_valid_i = 1'b1;
      s_addr_i  = a;
      s_data_i  = $urandom;
      s_last_i  = (k == len - 1);
      #1;
      if (s_ready_o) begin
        exp_data[k] = s_data_i;
        exp_addr[k] = a + 32'(4 * k);
        if (s_disc_o) got_disc = 1;
        if (s_last_i || s_disc_o) begin done = 1; ok_final = s_ok_o; end
        else if (s_ok_o) early_ok = 1;
        k++;
      end
    end
    @(posedge clk); #1;
    s_valid_i = 1'b0; s_last_i = 1'b0;
    acc_n = k;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (s_ready_o && !m_req_o) break;
    end
  endtask

  task automatic check_replay(input string tag);
    chk(cap_n == acc_n, tag, cap_n, acc_n);
    for (int i = 0; i < acc_n && i < 32; i++) begin
      chk(cap_addr[i] == exp_addr[i], tag, cap_addr[i], exp_addr[i]);
      chk(cap_data[i] == exp_data[i], tag, cap_data[i], exp_data[i]);
      chk(cap_last[i] == (i == acc_n - 1), tag, cap_last[i], i == acc_n - 1);
    end
  endtask

  task automatic posted_run(input logic [31:0] a, input int len, input bit slow);
    int c = exp_cut(a, len);
    ack_en = !slow;
    send_burst(a, len, 1'b0);
    chk(acc_n == c, "R6/R7 beats taken", acc_n, c);
    chk(got_disc == (len > c), "R6/R7 disconnect", got_disc, len > c);
    chk(ok_final && !early_ok, "R2 posted ok on final beat", ok_final, 1);
    if (slow) begin
      @(negedge clk); s_valid_i = 1'b1; s_addr_i = a; #1;
      chk(s_retry_o && !s_ready_o, "R4 retry while replay pending", {s_retry_o, s_ready_o}, 2'b10);
      @(posedge clk); #1; s_valid_i = 1'b0;
      ack_en = 1'b1;
    end
    wait_idle();
    chk(s_ready_o, "R5 accepts after replay", s_ready_o, 1);
    check_replay("R3 replay beat");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(s_ready_o && !m_req_o && sts_o == 0 && !irq_o, "R1 reset state",
        {s_ready_o, m_req_o, sts_o, irq_o}, 7'b1000000);

    // directed corners
    posted_run(32'h1000_0000, 20, 1'b0);  // R6 cut at 16
    posted_run(32'h1000_0030, 8, 1'b0);   // R7 boundary cut after 4
    posted_run(32'h1000_0030, 4, 1'b0);   // R7 ends on boundary with last, no disc
    posted_run(32'h2000_0008, 3, 1'b1);   // R4 retry window
    posted_run(32'h2000_003C, 2, 1'b0);   // R7 single beat at boundary

    // random mix
    for (int t = 0; t < 24; t++) begin
      logic [31:0] a = $urandom & 32'hFFFF_FFFC;
      int len = 1 + int'($urandom % 20);
      if ($urandom % 2) posted_run(a, len, 1'(t % 3 == 0));
      else begin
        ack_en = 1'b1;
        send_burst(a, len, 1'b1);
        chk(!ok_final && !early_ok, "R11 no early ok", ok_final, 0);
        begin
          bit seen = 0;
          int cap_at = 0;
          for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk); #1;
            if (s_ok_o) begin seen = 1; cap_at = cap_n; end
          end
          chk(seen && cap_at == acc_n, "R11 ok after replay", cap_at, acc_n);
        end
        wait_idle();
        check_replay("R3 non-posted replay");
      end
    end

    // posted target abort
    ack_en = 1'b0;
    send_burst(32'h3000_0000, 4, 1'b0);
    abort_req = 1;
    repeat (6) @(negedge clk); #1;
    chk(sts_o == 4'b0101, "R8 target abort flags", sts_o, 4'b0101);
    chk(!m_req_o && cap_n == 0, "R9 data discarded", {m_req_o, 8'(cap_n)}, 0);
    chk(s_ready_o, "R9 accepts after abort", s_ready_o, 1);
    chk(irq_o, "R10 irq unmasked", irq_o, 1);
    irq_mask_i = 4'b0101; #1;
    chk(!irq_o, "R10 irq masked", irq_o, 0);
    irq_mask_i = 4'b0100; #1;
    chk(irq_o, "R10 irq one bit open", irq_o, 1);
    irq_mask_i = 4'b0000;
    @(negedge clk); sts_clr_i = 4'b0001;
    @(negedge clk); sts_clr_i = 4'b0000; #1;
    chk(sts_o == 4'b0100, "R8 w1c single bit", sts_o, 4'b0100);
    @(negedge clk); #1;
    chk(sts_o == 4'b0100, "R8 sticky", sts_o, 4'b0100);
    @(negedge clk); sts_clr_i = 4'b1111;
    @(negedge clk); sts_clr_i = 4'b0000; #1;
    chk(sts_o == 0 && !irq_o, "R8 cleared", sts_o, 0);

    // posted master abort then new burst
    send_burst(32'h3000_0100, 6, 1'b0);
    abort_req = 2;
    repeat (6) @(negedge clk); #1;
    chk(sts_o == 4'b1010, "R8 master abort flags", sts_o, 4'b1010);
    chk(!m_req_o && cap_n == 0, "R9 discard on master abort", cap_n, 0);
    posted_run(32'h3000_0200, 5, 1'b0);
    @(negedge clk); sts_clr_i = 4'b1111;
    @(negedge clk); sts_clr_i = 4'b0000;

    // non-posted abort: error response, flags untouched
    ack_en = 1'b0;
    send_burst(32'h4000_0000, 3, 1'b1);
    abort_req = 1;
    begin
      bit err_seen = 0;
      for (int i = 0; i < 20 && !err_seen; i++) begin
        @(negedge clk); #1;
        if (s_err_o) err_seen = 1;
      end
      chk(err_seen, "R11 error response", err_seen, 1);
    end
    repeat (3) @(negedge clk); #1;
    chk(sts_o == 0, "R11 flags unchanged", sts_o, 0);
    chk(s_ready_o && !m_req_o, "R9 idle after non-posted abort", s_ready_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule